// File: doc/BRIEF.md
# Snooping Bus Arbiter with Cache Writeback Interlock

This block is the central arbitration logic for a shared local bus used by a processor with a writeback data cache and by several other bus masters. The processor owns the bus by default. When another master asks for the bus, the arbiter raises a hold request to the processor and waits for its acknowledge. It then issues a one-clock snoop strobe carrying the requester's address and an invalidate flag, which is set when the requester intends to write. Two clocks after the strobe it samples the processor's modified-hit indication. On a miss the requester is granted at once. On a hit the processor first writes the dirty line back with its own burst, and the requester is granted only after that burst ends and the hit indication has dropped.

The arbiter also sits on the processor's ready path. A ready from memory reaches the processor only while a processor bus cycle is open, and never while a snoop result is still outstanding. On read cycles the cacheability flag travels with each ready.

All control ports are active high. Any inversion of low-active bus pins happens outside this block. The other masters are served round-robin. A grant is withdrawn one clock after its request drops, and the hold to the processor is released in that same clock.

States: `ARB_IDLE` (processor owns the bus), `ARB_HOLD_WAIT` (hold raised, waiting for acknowledge), `ARB_STROBE` (snoop strobe), `ARB_GAP` (result not yet valid), `ARB_SAMPLE` (hit indication sampled), `ARB_WBACK` (processor writeback burst in progress), `ARB_DRAIN` (burst done, waiting for hit to clear), `ARB_GRANT` (requester owns the bus), `ARB_RELEASE` (grant and hold dropped).

Transitions:
- IDLE to HOLD_WAIT on any request.
- HOLD_WAIT to STROBE on acknowledge.
- STROBE to GAP, then GAP to SAMPLE, unconditionally.
- SAMPLE to GRANT on a miss, or to WBACK on a hit.
- WBACK to DRAIN on the last-beat-with-ready.
- DRAIN to GRANT once the hit indication is low.
- GRANT to RELEASE when the granted request drops.
- RELEASE to IDLE unconditionally.

Top module: `snoop_bus_arbiter`

## Requirements
- R1: After reset the hold, every grant, the snoop strobe and the processor ready are all low. The first request served is from master 0.
- R2: While the processor owns the bus (hold low for the present and the previous clock), any request raises the hold output in the next clock. The hold stays low while no master requests.
- R3: The first clock in which the hold acknowledge is seen high is followed by exactly one clock of snoop strobe. During that clock the snoop address equals the winning requester's address, and the invalidate flag equals that requester's write-intent bit.
- R4: If the hit indication is low two clocks after the strobe, the requester's grant bit (bit i for master i) is high in the following clock.
- R5: If the hit indication is high two clocks after the strobe, no grant is given and the hold stays high. The grant appears one clock after the first clock, following the processor's last-beat-with-ready, in which the hit indication is low.
- R6: The hold output is high in the clock where the hit indication first rises and in the clock after it.
- R7: The processor ready is forced low in the strobe clock and in the two clocks after it, whatever the memory ready.
- R8: The processor ready follows memory ready only inside a processor cycle. A cycle opens the clock after a start strobe and closes after a clock with last-beat and processor ready both high. Memory ready outside a cycle is ignored.
- R9: The cacheable flag is high exactly when the processor ready is high, the open cycle is a read (write-intent low at its start), and memory marks the line cacheable. It is never high on a write cycle.
- R10: Masters are served round-robin. The search starts one past the last master served, so simultaneous requests from masters 0 and 2 after master 1 was served go first to 2, then to 0.
- R11: A grant is removed one clock after its request drops, and the hold drops in that same clock.
- R12: At most one grant bit is high, and only while the hold is high and the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_REQ | Bus request, one bit per master |
| req_wr_i | input | NUM_REQ | Write intent per master (sets the invalidate flag) |
| req_addr_i | input | NUM_REQ*ADDR_W | Snoop address per master, master i at bits i*ADDR_W upward |
| grant_o | output | NUM_REQ | Bus grant, one-hot |
| cpu_hold_o | output | 1 | Hold request to the processor |
| cpu_hlda_i | input | 1 | Hold acknowledge from the processor |
| snoop_strobe_o | output | 1 | One-clock snoop strobe |
| snoop_inv_o | output | 1 | Invalidate request, valid with the strobe |
| snoop_addr_o | output | ADDR_W | Snoop address, valid with the strobe |
| cpu_hitm_i | input | 1 | Modified-line hit from the processor |
| cpu_ads_i | input | 1 | Processor cycle start strobe |
| cpu_wr_i | input | 1 | Processor cycle direction at start, 1 = write |
| cpu_blast_i | input | 1 | Processor last beat |
| mem_ready_i | input | 1 | Ready from the memory side |
| mem_cacheable_i | input | 1 | Line is writeback-cacheable |
| cpu_brdy_o | output | 1 | Ready delivered to the processor |
| cpu_wb_o | output | 1 | Cacheable flag, driven with the ready |

## Verification
The hold is due one clock after a request seen in the idle state. The acknowledge is modelled one clock behind the hold, so the strobe follows two clocks later, and the grant comes three clocks after the strobe on a miss. On a hit, the grant comes one clock after the first hit-free clock following the writeback's last beat. Ready and the cacheable flag are combinational, so they are due in the same clock as the memory ready. The bench drives inputs at the falling edge and compares every output against a behavioural model one nanosecond before the rising edge, then advances the model with the inputs of that clock, so each result is checked exactly in the clock it is due.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic [3:0] {
        ARB_IDLE,
        ARB_HOLD_WAIT,
        ARB_STROBE,
        ARB_GAP,
        ARB_SAMPLE,
        ARB_WBACK,
        ARB_DRAIN,
        ARB_GRANT,
        ARB_RELEASE
    } arb_state_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int NUM_REQ = 3,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               load_i,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic               win_any_o
);
    logic [IDX_W-1:0] last_q;

    // Pointer to the last master served; search begins just past it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(NUM_REQ - 1);
        else if (load_i)
            last_q <= win_idx_o;
    end

    always_comb begin
        int cand;
        cand      = 0;
        win_any_o = 1'b0;
        win_idx_o = '0;
        for (int off = 1; off <= NUM_REQ; off++) begin
            cand = int'(last_q) + off;
            if (cand >= NUM_REQ)
                cand = cand - NUM_REQ;
            if (!win_any_o && req_i[cand]) begin
                win_any_o = 1'b1;
                win_idx_o = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/sba_ready_gate.sv
module sba_ready_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ads_i,
    input  logic wr_i,
    input  logic blast_i,
    input  logic mem_ready_i,
    input  logic cacheable_i,
    input  logic snoop_pending_i,
    output logic brdy_o,
    output logic wb_o,
    output logic burst_end_o
);
    logic in_cycle_q;
    logic cur_wr_q;

    // Track the open processor cycle and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cycle_q <= 1'b0;
            cur_wr_q   <= 1'b0;
        end else if (ads_i) begin
            in_cycle_q <= 1'b1;
            cur_wr_q   <= wr_i;
        end else if (burst_end_o) begin
            in_cycle_q <= 1'b0;
        end
    end

    always_comb begin
        brdy_o      = mem_ready_i && in_cycle_q && !snoop_pending_i;
        wb_o        = brdy_o && !cur_wr_q && cacheable_i;
        burst_end_o = brdy_o && blast_i;
    end
endmodule

// File: rtl/sba_ctrl.sv
module sba_ctrl
    import sba_pkg::*;
#(
    parameter int NUM_REQ = 3,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] req_wr_i,
    input  logic [IDX_W-1:0]   win_idx_i,
    input  logic               win_any_i,
    input  logic               hlda_i,
    input  logic               hitm_i,
    input  logic               burst_end_i,
    output logic               load_ptr_o,
    output logic [IDX_W-1:0]   sel_idx_o,
    output logic               hold_o,
    output logic               strobe_o,
    output logic               inv_o,
    output logic               pending_o,
    output logic [NUM_REQ-1:0] grant_o
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] sel_q;
    logic [NUM_REQ-1:0] sel_hot;
    logic             grant_en;
    logic             sel_req;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_sel
        assign sel_hot[g] = (sel_q == IDX_W'(g));
        assign grant_o[g] = grant_en && sel_hot[g];
    end

    assign sel_req   = |(req_i & sel_hot);
    assign sel_idx_o = sel_q;

    // State register and latched requester index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_ptr_o)
                sel_q <= win_idx_i;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:      if (win_any_i) state_d = ARB_HOLD_WAIT;
            ARB_HOLD_WAIT: if (hlda_i) state_d = ARB_STROBE;
            ARB_STROBE:    state_d = ARB_GAP;
            ARB_GAP:       state_d = ARB_SAMPLE;
            ARB_SAMPLE:    state_d = hitm_i ? ARB_WBACK : ARB_GRANT;
            ARB_WBACK:     if (burst_end_i) state_d = ARB_DRAIN;
            ARB_DRAIN:     if (!hitm_i) state_d = ARB_GRANT;
            ARB_GRANT:     if (!sel_req) state_d = ARB_RELEASE;
            ARB_RELEASE:   state_d = ARB_IDLE;
            default:       state_d = ARB_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        load_ptr_o = 1'b0;
        hold_o     = 1'b0;
        strobe_o   = 1'b0;
        inv_o      = 1'b0;
        pending_o  = 1'b0;
        grant_en   = 1'b0;
        unique case (state_q)
            ARB_IDLE:      load_ptr_o = win_any_i;
            ARB_HOLD_WAIT: hold_o = 1'b1;
            ARB_STROBE: begin
                hold_o    = 1'b1;
                strobe_o  = 1'b1;
                inv_o     = |(req_wr_i & sel_hot);
                pending_o = 1'b1;
            end
            ARB_GAP, ARB_SAMPLE: begin
                hold_o    = 1'b1;
                pending_o = 1'b1;
            end
            ARB_WBACK, ARB_DRAIN: hold_o = 1'b1;
            ARB_GRANT: begin
                hold_o   = 1'b1;
                grant_en = 1'b1;
            end
            ARB_RELEASE: hold_o = 1'b0;
            default:     hold_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter #(
    parameter int NUM_REQ = 3,
    parameter int ADDR_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_i,
    input  logic [NUM_REQ-1:0]        req_wr_i,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr_i,
    output logic [NUM_REQ-1:0]        grant_o,
    output logic                      cpu_hold_o,
    input  logic                      cpu_hlda_i,
    output logic                      snoop_strobe_o,
    output logic                      snoop_inv_o,
    output logic [ADDR_W-1:0]         snoop_addr_o,
    input  logic                      cpu_hitm_i,
    input  logic                      cpu_ads_i,
    input  logic                      cpu_wr_i,
    input  logic                      cpu_blast_i,
    input  logic                      mem_ready_i,
    input  logic                      mem_cacheable_i,
    output logic                      cpu_brdy_o,
    output logic                      cpu_wb_o
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             load_ptr;
    logic [IDX_W-1:0] sel_idx;
    logic             pending;
    logic             burst_end;

    sba_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) rr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .load_i    (load_ptr),
        .win_idx_o (win_idx),
        .win_any_o (win_any)
    );

    sba_ctrl #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_wr_i    (req_wr_i),
        .win_idx_i   (win_idx),
        .win_any_i   (win_any),
        .hlda_i      (cpu_hlda_i),
        .hitm_i      (cpu_hitm_i),
        .burst_end_i (burst_end),
        .load_ptr_o  (load_ptr),
        .sel_idx_o   (sel_idx),
        .hold_o      (cpu_hold_o),
        .strobe_o    (snoop_strobe_o),
        .inv_o       (snoop_inv_o),
        .pending_o   (pending),
        .grant_o     (grant_o)
    );

    sba_ready_gate gate_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .ads_i           (cpu_ads_i),
        .wr_i            (cpu_wr_i),
        .blast_i         (cpu_blast_i),
        .mem_ready_i     (mem_ready_i),
        .cacheable_i     (mem_cacheable_i),
        .snoop_pending_i (pending),
        .brdy_o          (cpu_brdy_o),
        .wb_o            (cpu_wb_o),
        .burst_end_o     (burst_end)
    );

    // Snoop address taken from the latched requester.
    always_comb begin
        snoop_addr_o = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (sel_idx == IDX_W'(k))
                snoop_addr_o = req_addr_i[k*ADDR_W +: ADDR_W];
        end
    end
endmodule

// File: rtl/snoop_bus_arbiter_chk.sv
module snoop_bus_arbiter_chk #(
    parameter int NUM_REQ = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] grant_o,
    input logic               cpu_hold_o,
    input logic               cpu_hlda_i,
    input logic               snoop_strobe_o,
    input logic               cpu_hitm_i,
    input logic               cpu_brdy_o,
    input logic               cpu_wb_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_hold_o && grant_o == '0 && !snoop_strobe_o));

    assert_hold_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hold_o && !$past(cpu_hold_o) && |req_i) |=> cpu_hold_o);

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_strobe_o |=> !snoop_strobe_o);

    assert_strobe_under_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_strobe_o |-> cpu_hold_o);

    assert_grant_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(snoop_strobe_o, 2) && !cpu_hitm_i) |=> grant_o != '0);

    assert_no_grant_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(snoop_strobe_o, 2) && cpu_hitm_i) |=> (grant_o == '0 && cpu_hold_o));

    assert_hitm_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hitm_i) |-> cpu_hold_o ##1 cpu_hold_o);

    assert_ready_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_strobe_o || $past(snoop_strobe_o) || $past(snoop_strobe_o, 2)) |-> !cpu_brdy_o);

    assert_cacheable_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wb_o |-> cpu_brdy_o);

    assert_grant_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant_o & ~req_i)) |=> (grant_o == '0 && !cpu_hold_o));

    assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_needs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> (cpu_hold_o && cpu_hlda_i));
endmodule

bind snoop_bus_arbiter snoop_bus_arbiter_chk #(.NUM_REQ(NUM_REQ)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (req_i),
    .grant_o        (grant_o),
    .cpu_hold_o     (cpu_hold_o),
    .cpu_hlda_i     (cpu_hlda_i),
    .snoop_strobe_o (snoop_strobe_o),
    .cpu_hitm_i     (cpu_hitm_i),
    .cpu_brdy_o     (cpu_brdy_o),
    .cpu_wb_o       (cpu_wb_o)
);

// File: tb/snoop_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module snoop_bus_arbiter_tb_top;
    localparam int N  = 3;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, req_wr = '0;
    logic [N*AW-1:0] req_addr;
    logic [N-1:0] grant;
    logic hold, hlda = 1'b0, strobe, inv, hitm = 1'b0;
    logic [AW-1:0] saddr;
    logic ads = 1'b0, wr = 1'b0, blast = 1'b0, ready = 1'b0, cacheable = 1'b0;
    logic brdy, wb;

    int n_chk = 0, n_err = 0;

    // Behavioural reference state
    int m_idx = -1, m_last = N - 1, m_age = -1;
    bit m_hold = 0, m_wait = 0, m_hit = 0, m_wbdone = 0, m_grant = 0, m_rel = 0;
    bit m_incyc = 0, m_curwr = 0;
    bit prev_hitm = 0, hitm_rise_prev = 0;
    logic [N-1:0] prev_grant = '0;
    int served[$];

    always #5 clk = ~clk;

    for (genvar k = 0; k < N; k++) begin : g_addr
        assign req_addr[k*AW +: AW] = 32'h4000_0000 + 32'h0001_0040 * k;
    end

    snoop_bus_arbiter #(.NUM_REQ(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr),
        .grant_o(grant), .cpu_hold_o(hold), .cpu_hlda_i(hlda), .snoop_strobe_o(strobe),
        .snoop_inv_o(inv), .snoop_addr_o(saddr), .cpu_hitm_i(hitm), .cpu_ads_i(ads),
        .cpu_wr_i(wr), .cpu_blast_i(blast), .mem_ready_i(ready),
        .mem_cacheable_i(cacheable), .cpu_brdy_o(brdy), .cpu_wb_o(wb)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: compare just before the rising edge, then advance the model.
    task automatic tick();
        bit e_pend, e_brdy, e_wb, e_hold, rose;
        logic [N-1:0] e_grant;
        int pick;
        #4;
        e_pend  = (m_age >= 0);
        e_brdy  = ready && m_incyc && !e_pend;
        e_wb    = e_brdy && !m_curwr && cacheable;
        e_grant = m_grant ? N'(1 << m_idx) : '0;
        e_hold  = m_hold;
        chk("R2 hold", hold, e_hold);
        chk("R3 strobe", strobe, m_age == 0);
        if (m_age == 0) begin
            chk("R3 snoop address", saddr, req_addr[m_idx*AW +: AW]);
            chk("R3 invalidate", inv, req_wr[m_idx]);
        end
        chk(m_hit ? "R5 grant withheld" : "R4/R11 grant", grant, e_grant);
        chk(e_pend ? "R7 ready gated" : "R8 ready", brdy, e_brdy);
        chk("R9 cacheable", wb, e_wb);
        chk("R12 grant onehot", $countones(grant) <= 1, 1);
        rose = hitm && !prev_hitm;
        if (rose || hitm_rise_prev) chk("R6 hold around HITM rise", hold, 1);
        hitm_rise_prev = rose;
        prev_hitm = hitm;
        if (grant != '0 && prev_grant == '0)
            for (int k = 0; k < N; k++) if (grant[k]) served.push_back(k);
        prev_grant = grant;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_idx = -1; m_last = N - 1; m_age = -1;
            m_hold = 0; m_wait = 0; m_hit = 0; m_wbdone = 0; m_grant = 0; m_rel = 0;
            m_incyc = 0; m_curwr = 0;
        end else begin
            if (ads) begin m_incyc = 1; m_curwr = wr; end
            else if (blast && e_brdy) m_incyc = 0;
            if (m_rel) m_rel = 0;
            else if (!m_hold) begin
                pick = -1;
                for (int off = 1; off <= N; off++)
                    if (pick < 0 && req[(m_last + off) % N]) pick = (m_last + off) % N;
                if (pick >= 0) begin
                    m_idx = pick; m_last = pick; m_hold = 1; m_wait = 1;
                end
            end else if (m_wait) begin
                if (hlda) begin m_wait = 0; m_age = 0; end
            end else if (m_age >= 0) begin
                if (m_age < 2) m_age++;
                else begin
                    m_age = -1;
                    if (hitm) m_hit = 1; else m_grant = 1;
                end
            end else if (m_hit) begin
                if (!m_wbdone) begin
                    if (blast && e_brdy) m_wbdone = 1;
                end else if (!hitm) begin
                    m_hit = 0; m_wbdone = 0; m_grant = 1;
                end
            end else if (m_grant) begin
                if (!req[m_idx]) begin m_grant = 0; m_hold = 0; m_rel = 1; end
            end
        end
        hlda = e_hold;  // processor acknowledges one clock after hold
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        repeat (2) tick();
        rst_n = 1'b1;
        // R1 / R8: idle after reset, stray memory ready ignored
        ready = 1'b1;
        tick();
        #4;
        chk("R1 hold after reset", hold, 0);
        chk("R1 grant after reset", grant, 0);
        chk("R1 strobe after reset", strobe, 0);
        chk("R8 ready outside cycle", brdy, 0);
        @(negedge clk);
        ready = 1'b0;
        tick();

        // R9 / R8: cacheable read burst of four beats, then a single write
        ads = 1; wr = 0; cacheable = 1; tick();
        ads = 0; ready = 1;
        repeat (3) tick();
        blast = 1; tick();
        blast = 0; ready = 0; tick();
        ads = 1; wr = 1; tick();
        ads = 0; ready = 1; blast = 1; tick();
        ready = 0; blast = 0; cacheable = 0; tick();

        // R2 / R3 / R4 / R11: master 0 writes, snoop misses
        req = 3'b001; req_wr = 3'b001;
        while (!m_grant) tick();
        repeat (3) tick();
        req = '0;
        repeat (4) tick();

        // R5 / R6: master 1 reads, snoop hits a modified line
        req = 3'b010; req_wr = 3'b000;
        while (m_age != 1) tick();
        hitm = 1; tick();
        tick();
        ads = 1; wr = 1; tick();
        ads = 0; ready = 1;
        repeat (3) tick();
        blast = 1; tick();
        blast = 0; ready = 0; tick();
        #4;
        chk("R5 no grant before HITM clears", grant, 0);
        chk("R5 hold kept during writeback", hold, 1);
        @(negedge clk);
        tick();
        hitm = 0;
        while (!m_grant) tick();
        req = '0;
        repeat (4) tick();

        // R7 / R10: processor read in flight while masters 0 and 2 request
        ads = 1; wr = 0; cacheable = 1; tick();
        ads = 0; ready = 1;
        req = 3'b101; req_wr = 3'b100;
        while (!m_grant) tick();
        blast = 1; tick();
        blast = 0; ready = 0; cacheable = 0;
        req = 3'b001;
        while (!(m_grant && m_idx == 0)) tick();
        req = '0;
        repeat (4) tick();

        chk("R10 served count", served.size(), 4);
        if (served.size() == 4) begin
            chk("R10 order first", served[0], 0);
            chk("R10 order second", served[1], 1);
            chk("R10 order third", served[2], 2);
            chk("R10 order fourth", served[3], 0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule